// File: doc/BRIEF.md
# Shared Buffer Admission Controller

This block decides, packet by packet, whether an arriving packet may enter a switch whose storage is one shared pool of fixed-size cells. It works out how many cells the packet will occupy, given that the first cell gives up part of its space to a metadata header. It then tests that cell count against every counter the packet touches. On the arrival side these are its priority group, its ingress port and the ingress service pool. On the departure side they are its egress queue, its egress port and the egress service pool.

Each per-entity limit is the smaller of two values. One is a fixed ceiling. The other is the pool's remaining free cells scaled by a power of two. When a packet is accepted, its cells are charged to all six counters at once. When the cells are later dequeued, a release request with the same identifiers takes them back off. A rejected packet leaves every counter untouched.

The release port and the admission port are independent and may both be active in one cycle. The decision for each admission request is reported on the next cycle.

Top module: `sbuf_admit`

## Requirements
- R1: The reported cell count for a packet of L bytes is 1 when L <= CELL_BYTES-META_BYTES, and otherwise 1 + ceil((L-(CELL_BYTES-META_BYTES))/CELL_BYTES). With the default 208-byte cells and 64-byte header, lengths 100, 144, 145, 352, 353 and 16383 give 1, 1, 2, 2, 3 and 80 cells.
- R2: `respValid` is high in exactly the cycle after a cycle with `reqValid` high. `respAdmit` and `respCells` carry that request's result, and `respAdmit` is never high without `respValid`.
- R3: A packet is dropped when its cells added to the current count of its priority group, or of its ingress port, would exceed that entity's limit.
- R4: A packet is dropped when its cells added to the current count of its egress queue, or of its egress port, would exceed that entity's limit.
- R5: An entity's limit is min(static, dyn), where dyn = free << alpha for alpha >= 0 and free >> -alpha for alpha < 0, and free = POOL_CELLS minus the cells in use.
- R6: A packet is dropped when the ingress pool total would exceed ING_POOL_LIMIT, when the egress pool total would exceed EGR_POOL_LIMIT, or when the total in use would exceed POOL_CELLS. The total in use never exceeds POOL_CELLS.
- R7: An admitted packet raises the ingress and egress pool totals together by its cell count, so `poolUsed` rises by exactly that count. A release lowers it by the released count.
- R8: A dropped packet changes no counter, and `poolUsed` keeps its value.
- R9: When a release and an admission request arrive in the same cycle, the release is applied first, and the admission test uses the counts as they stand after the release.
- R10: A release whose cell count is larger than any of the six counters it names is ignored completely and sets `relError`. `relError` stays set until reset.
- R11: After reset, `poolUsed` is 0, `respValid` is 0 and `relError` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Admission request strobe |
| reqLen | input | LEN_W | Packet length in bytes |
| reqPg | input | clog2(NUM_PG) | Priority group of the packet |
| reqInPort | input | clog2(NUM_PORTS) | Ingress port |
| reqOutPort | input | clog2(NUM_PORTS) | Egress port |
| reqQueue | input | clog2(NUM_Q) | Egress queue (global index) |
| relValid | input | 1 | Release strobe |
| relCells | input | CELLW | Number of cells being released |
| relPg | input | clog2(NUM_PG) | Priority group charged by the released cells |
| relInPort | input | clog2(NUM_PORTS) | Ingress port charged |
| relOutPort | input | clog2(NUM_PORTS) | Egress port charged |
| relQueue | input | clog2(NUM_Q) | Egress queue charged |
| respValid | output | 1 | Decision valid, one cycle after the request |
| respAdmit | output | 1 | 1 = admitted, 0 = dropped |
| respCells | output | CELLW | Cell count computed for the request |
| relError | output | 1 | Sticky flag for a release that would underflow |
| poolUsed | output | CW | Cells currently in use in the shared pool |

## Verification
The bench builds the block with a 64-cell pool so that every kind of limit can be reached with a few dozen packets. It uses four priority groups, four ports and eight queues, a positive alpha on groups and ports, and a negative alpha (-1) on queues. With these values, the halving of the free count can be made to undercut the queue's static ceiling, and the egress pool ceiling of 56 can be made the only limit a packet breaks. The 14-bit length input reaches the 80-cell maximum, which is larger than the whole pool, so an oversize drop is also covered.

// File: rtl/sbuf_admit_pkg.sv
package sbuf_admit_pkg;

  // Strobes from the decision logic to the counter datapath
  typedef struct packed {
    logic relApply;   // apply the release to all six counters
    logic admApply;   // charge the admitted cells
    logic errSet;     // release would underflow
    logic respValid;  // a request is being decided this cycle
    logic respAdmit;  // decision for that request
  } admStrobeT;

  // Cells needed for a packet: the first cell loses metaB bytes to the header
  function automatic int unsigned cellsFor(input int unsigned len,
                                           input int unsigned cellB,
                                           input int unsigned metaB);
    int unsigned room0;
    room0 = cellB - metaB;
    if (len <= room0) return 1;
    return 1 + (len - room0 + cellB - 1) / cellB;
  endfunction

  // Effective limit: smaller of static ceiling and scaled free count
  function automatic int unsigned limitOf(input int unsigned staticLim,
                                          input int alpha,
                                          input int unsigned freeCells);
    int unsigned dyn;
    if (alpha >= 0) dyn = freeCells << alpha;
    else            dyn = freeCells >> (-alpha);
    return (dyn < staticLim) ? dyn : staticLim;
  endfunction

endpackage

// File: rtl/sbuf_admit_bank.sv
module sbuf_admit_bank #(
  parameter int N  = 4,
  parameter int CW = 7,
  parameter int AW = 7,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          relApply,
  input  logic [IW-1:0] relIdx,
  input  logic [AW-1:0] relAmt,
  input  logic          admApply,
  input  logic [IW-1:0] admIdx,
  input  logic [AW-1:0] admAmt,
  output logic [CW-1:0] relCnt,
  output logic [CW-1:0] admCnt
);

  logic [CW-1:0] cnt [N];

  for (genvar i = 0; i < N; i++) begin : gEntry
    logic [31:0] subV, addV, nextV;
    always_comb begin
      subV  = (relApply && relIdx == IW'(i)) ? 32'(relAmt) : 32'd0;
      addV  = (admApply && admIdx == IW'(i)) ? 32'(admAmt) : 32'd0;
      nextV = 32'(cnt[i]) - subV + addV;
    end
    always_ff @(posedge clk) begin
      if (!rstN) cnt[i] <= '0;
      else       cnt[i] <= CW'(nextV);
    end
  end

  assign relCnt = cnt[relIdx];
  assign admCnt = cnt[admIdx];

  // R10
  rel_within_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    relApply |-> 32'(relAmt) <= 32'(relCnt));

endmodule

// File: rtl/sbuf_admit_ctrl.sv
module sbuf_admit_ctrl
  import sbuf_admit_pkg::*;
#(
  parameter int CELL_BYTES = 208,
  parameter int META_BYTES = 64,
  parameter int LEN_W = 14,
  parameter int NUM_PG = 4,
  parameter int NUM_PORTS = 4,
  parameter int NUM_Q = 8,
  parameter int POOL_CELLS = 64,
  parameter int ING_POOL_LIMIT = 60,
  parameter int EGR_POOL_LIMIT = 56,
  parameter int PG_STATIC = 24,
  parameter int PG_ALPHA = 1,
  parameter int INP_STATIC = 40,
  parameter int INP_ALPHA = 1,
  parameter int Q_STATIC = 28,
  parameter int Q_ALPHA = -1,
  parameter int OUTP_STATIC = 40,
  parameter int OUTP_ALPHA = 1,
  parameter int CW = 7,
  parameter int CELLW = 7,
  localparam int PGW = $clog2(NUM_PG),
  localparam int PW = $clog2(NUM_PORTS),
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [PGW-1:0]   reqPg,
  input  logic [PW-1:0]    reqInPort,
  input  logic [PW-1:0]    reqOutPort,
  input  logic [QW-1:0]    reqQueue,
  input  logic             relValid,
  input  logic [CELLW-1:0] relCells,
  input  logic [PGW-1:0]   relPg,
  input  logic [PW-1:0]    relInPort,
  input  logic [PW-1:0]    relOutPort,
  input  logic [QW-1:0]    relQueue,
  input  logic [CW-1:0]    relPgCnt, relInCnt, relOutCnt, relQCnt,
  input  logic [CW-1:0]    admPgCnt, admInCnt, admOutCnt, admQCnt,
  input  logic [CW-1:0]    ingPool,
  input  logic [CW-1:0]    egrPool,
  output admStrobeT        str,
  output logic [CELLW-1:0] cellsNow
);

  logic [31:0] need, relAmt;
  logic [31:0] postPg, postIn, postOut, postQ, postIng, postEgr, freeCells;
  logic        relOk, fitIng, fitEgr, admit;

  always_comb begin
    need     = cellsFor(32'(reqLen), CELL_BYTES, META_BYTES);
    cellsNow = CELLW'(need);

    relOk = 32'(relCells) <= 32'(relPgCnt) && 32'(relCells) <= 32'(relInCnt) &&
            32'(relCells) <= 32'(relOutCnt) && 32'(relCells) <= 32'(relQCnt) &&
            32'(relCells) <= 32'(ingPool) && 32'(relCells) <= 32'(egrPool);
    str.relApply = relValid && relOk;
    str.errSet   = relValid && !relOk;
    relAmt = str.relApply ? 32'(relCells) : 32'd0;

    // counts as they stand after this cycle's release
    postPg  = 32'(admPgCnt)  - ((relPg == reqPg)           ? relAmt : 32'd0);
    postIn  = 32'(admInCnt)  - ((relInPort == reqInPort)   ? relAmt : 32'd0);
    postOut = 32'(admOutCnt) - ((relOutPort == reqOutPort) ? relAmt : 32'd0);
    postQ   = 32'(admQCnt)   - ((relQueue == reqQueue)     ? relAmt : 32'd0);
    postIng = 32'(ingPool) - relAmt;
    postEgr = 32'(egrPool) - relAmt;
    freeCells = 32'(POOL_CELLS) - postIng;

    fitIng = postPg + need <= limitOf(PG_STATIC, PG_ALPHA, freeCells) &&
             postIn + need <= limitOf(INP_STATIC, INP_ALPHA, freeCells) &&
             postIng + need <= 32'(ING_POOL_LIMIT);
    fitEgr = postQ + need <= limitOf(Q_STATIC, Q_ALPHA, freeCells) &&
             postOut + need <= limitOf(OUTP_STATIC, OUTP_ALPHA, freeCells) &&
             postEgr + need <= 32'(EGR_POOL_LIMIT);
    admit  = reqValid && fitIng && fitEgr && (postIng + need <= 32'(POOL_CELLS));

    str.admApply  = admit;
    str.respValid = reqValid;
    str.respAdmit = admit;
  end

endmodule

// File: rtl/sbuf_admit_dp.sv
module sbuf_admit_dp
  import sbuf_admit_pkg::*;
#(
  parameter int NUM_PG = 4,
  parameter int NUM_PORTS = 4,
  parameter int NUM_Q = 8,
  parameter int POOL_CELLS = 64,
  parameter int CW = 7,
  parameter int CELLW = 7,
  localparam int PGW = $clog2(NUM_PG),
  localparam int PW = $clog2(NUM_PORTS),
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rstN,
  input  admStrobeT        str,
  input  logic [CELLW-1:0] admCells,
  input  logic [CELLW-1:0] relCells,
  input  logic [PGW-1:0]   reqPg, relPg,
  input  logic [PW-1:0]    reqInPort, relInPort,
  input  logic [PW-1:0]    reqOutPort, relOutPort,
  input  logic [QW-1:0]    reqQueue, relQueue,
  output logic [CW-1:0]    relPgCnt, relInCnt, relOutCnt, relQCnt,
  output logic [CW-1:0]    admPgCnt, admInCnt, admOutCnt, admQCnt,
  output logic [CW-1:0]    ingPool,
  output logic [CW-1:0]    egrPool,
  output logic             respValid,
  output logic             respAdmit,
  output logic [CELLW-1:0] respCells,
  output logic             relError
);

  sbuf_admit_bank #(.N(NUM_PG), .CW(CW), .AW(CELLW)) u_pgBank (
    .clk, .rstN, .relApply(str.relApply), .relIdx(relPg), .relAmt(relCells),
    .admApply(str.admApply), .admIdx(reqPg), .admAmt(admCells),
    .relCnt(relPgCnt), .admCnt(admPgCnt));

  sbuf_admit_bank #(.N(NUM_PORTS), .CW(CW), .AW(CELLW)) u_inBank (
    .clk, .rstN, .relApply(str.relApply), .relIdx(relInPort), .relAmt(relCells),
    .admApply(str.admApply), .admIdx(reqInPort), .admAmt(admCells),
    .relCnt(relInCnt), .admCnt(admInCnt));

  sbuf_admit_bank #(.N(NUM_PORTS), .CW(CW), .AW(CELLW)) u_outBank (
    .clk, .rstN, .relApply(str.relApply), .relIdx(relOutPort), .relAmt(relCells),
    .admApply(str.admApply), .admIdx(reqOutPort), .admAmt(admCells),
    .relCnt(relOutCnt), .admCnt(admOutCnt));

  sbuf_admit_bank #(.N(NUM_Q), .CW(CW), .AW(CELLW)) u_qBank (
    .clk, .rstN, .relApply(str.relApply), .relIdx(relQueue), .relAmt(relCells),
    .admApply(str.admApply), .admIdx(reqQueue), .admAmt(admCells),
    .relCnt(relQCnt), .admCnt(admQCnt));

  logic [31:0] poolDelta;
  assign poolDelta = (str.admApply ? 32'(admCells) : 32'd0)
                   - (str.relApply ? 32'(relCells) : 32'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ingPool   <= '0;
      egrPool   <= '0;
      respValid <= 1'b0;
      respAdmit <= 1'b0;
      respCells <= '0;
      relError  <= 1'b0;
    end else begin
      ingPool   <= CW'(32'(ingPool) + poolDelta);
      egrPool   <= CW'(32'(egrPool) + poolDelta);
      respValid <= str.respValid;
      respAdmit <= str.respAdmit;
      respCells <= admCells;
      if (str.errSet) relError <= 1'b1;
    end
  end

  // R7
  pools_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ingPool == egrPool);

  // R6
  pool_ceiling_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(ingPool) <= 32'(POOL_CELLS));

  // R2
  admit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    respAdmit |-> respValid);

  // R8
  drop_keeps_pool_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respAdmit && !$past(str.relApply)) |-> ingPool == $past(ingPool));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(relError) |-> relError);

endmodule

// File: rtl/sbuf_admit.sv
module sbuf_admit
  import sbuf_admit_pkg::*;
#(
  parameter int CELL_BYTES = 208,
  parameter int META_BYTES = 64,
  parameter int LEN_W = 14,
  parameter int NUM_PG = 4,
  parameter int NUM_PORTS = 4,
  parameter int NUM_Q = 8,
  parameter int POOL_CELLS = 64,
  parameter int ING_POOL_LIMIT = 60,
  parameter int EGR_POOL_LIMIT = 56,
  parameter int PG_STATIC = 24,
  parameter int PG_ALPHA = 1,
  parameter int INP_STATIC = 40,
  parameter int INP_ALPHA = 1,
  parameter int Q_STATIC = 28,
  parameter int Q_ALPHA = -1,
  parameter int OUTP_STATIC = 40,
  parameter int OUTP_ALPHA = 1,
  localparam int MAX_LEN = (1 << LEN_W) - 1,
  localparam int MAX_CELLS = 1 + (MAX_LEN - (CELL_BYTES - META_BYTES) + CELL_BYTES - 1) / CELL_BYTES,
  localparam int CELLW = $clog2(MAX_CELLS + 1),
  localparam int CW = $clog2(POOL_CELLS + 1),
  localparam int PGW = $clog2(NUM_PG),
  localparam int PW = $clog2(NUM_PORTS),
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [PGW-1:0]   reqPg,
  input  logic [PW-1:0]    reqInPort,
  input  logic [PW-1:0]    reqOutPort,
  input  logic [QW-1:0]    reqQueue,
  input  logic             relValid,
  input  logic [CELLW-1:0] relCells,
  input  logic [PGW-1:0]   relPg,
  input  logic [PW-1:0]    relInPort,
  input  logic [PW-1:0]    relOutPort,
  input  logic [QW-1:0]    relQueue,
  output logic             respValid,
  output logic             respAdmit,
  output logic [CELLW-1:0] respCells,
  output logic             relError,
  output logic [CW-1:0]    poolUsed
);

  admStrobeT        str;
  logic [CELLW-1:0] cellsNow;
  logic [CW-1:0]    relPgCnt, relInCnt, relOutCnt, relQCnt;
  logic [CW-1:0]    admPgCnt, admInCnt, admOutCnt, admQCnt;
  logic [CW-1:0]    ingPool, egrPool;

  sbuf_admit_ctrl #(
    .CELL_BYTES(CELL_BYTES), .META_BYTES(META_BYTES), .LEN_W(LEN_W),
    .NUM_PG(NUM_PG), .NUM_PORTS(NUM_PORTS), .NUM_Q(NUM_Q),
    .POOL_CELLS(POOL_CELLS), .ING_POOL_LIMIT(ING_POOL_LIMIT), .EGR_POOL_LIMIT(EGR_POOL_LIMIT),
    .PG_STATIC(PG_STATIC), .PG_ALPHA(PG_ALPHA), .INP_STATIC(INP_STATIC), .INP_ALPHA(INP_ALPHA),
    .Q_STATIC(Q_STATIC), .Q_ALPHA(Q_ALPHA), .OUTP_STATIC(OUTP_STATIC), .OUTP_ALPHA(OUTP_ALPHA),
    .CW(CW), .CELLW(CELLW)
  ) u_ctrl (
    .reqValid, .reqLen, .reqPg, .reqInPort, .reqOutPort, .reqQueue,
    .relValid, .relCells, .relPg, .relInPort, .relOutPort, .relQueue,
    .relPgCnt, .relInCnt, .relOutCnt, .relQCnt,
    .admPgCnt, .admInCnt, .admOutCnt, .admQCnt,
    .ingPool, .egrPool, .str, .cellsNow
  );

  sbuf_admit_dp #(
    .NUM_PG(NUM_PG), .NUM_PORTS(NUM_PORTS), .NUM_Q(NUM_Q),
    .POOL_CELLS(POOL_CELLS), .CW(CW), .CELLW(CELLW)
  ) u_dp (
    .clk, .rstN, .str, .admCells(cellsNow), .relCells,
    .reqPg, .relPg, .reqInPort, .relInPort, .reqOutPort, .relOutPort,
    .reqQueue, .relQueue,
    .relPgCnt, .relInCnt, .relOutCnt, .relQCnt,
    .admPgCnt, .admInCnt, .admOutCnt, .admQCnt,
    .ingPool, .egrPool, .respValid, .respAdmit, .respCells, .relError
  );

  assign poolUsed = ingPool;

endmodule

// File: tb/sbuf_admit_bench.sv
module sbuf_admit_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CELLB = 208, METAB = 64, POOL = 64;
  localparam int ING_LIM = 60, EGR_LIM = 56;
  localparam int NPG = 4, NP = 4, NQ = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, relValid = 0;
  logic [13:0] reqLen = '0;
  logic [1:0] reqPg = '0, reqInPort = '0, reqOutPort = '0, relPg = '0, relInPort = '0, relOutPort = '0;
  logic [2:0] reqQueue = '0, relQueue = '0;
  logic [6:0] relCells = '0;
  logic respValid, respAdmit, relError;
  logic [6:0] respCells, poolUsed;

  always #2.5 clk = ~clk;

  sbuf_admit u_sbuf_admit (
    .clk, .rstN, .reqValid, .reqLen, .reqPg, .reqInPort, .reqOutPort, .reqQueue,
    .relValid, .relCells, .relPg, .relInPort, .relOutPort, .relQueue,
    .respValid, .respAdmit, .respCells, .relError, .poolUsed);

  int nChecks = 0, nFails = 0;
  int mPg[NPG], mIn[NP], mOut[NP], mQ[NQ];
  int mUsed, mErr, eValid, eAdmit, eCells;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cellsOf(input int len);
    if (len <= CELLB - METAB) return 1;
    return 1 + (len - (CELLB - METAB) + CELLB - 1) / CELLB;
  endfunction

  function automatic int lim(input int st, input int al, input int fr);
    int d;
    d = (al >= 0) ? (fr << al) : (fr >> (-al));
    return (d < st) ? d : st;
  endfunction

  task automatic modelReset();
    foreach (mPg[i]) mPg[i] = 0;
    foreach (mIn[i]) mIn[i] = 0;
    foreach (mOut[i]) mOut[i] = 0;
    foreach (mQ[i]) mQ[i] = 0;
    mUsed = 0; mErr = 0; eValid = 0; eAdmit = 0; eCells = 0;
  endtask

  task automatic cyc(input bit rv, input int len, input int pg, input int ip, input int op, input int q,
                     input bit lv, input int lc, input int lpg, input int lip, input int lop, input int lq);
    int c, fr;
    bit ok;
    @(negedge clk);
    reqValid = rv; reqLen = 14'(len); reqPg = 2'(pg); reqInPort = 2'(ip);
    reqOutPort = 2'(op); reqQueue = 3'(q);
    relValid = lv; relCells = 7'(lc); relPg = 2'(lpg); relInPort = 2'(lip);
    relOutPort = 2'(lop); relQueue = 3'(lq);
    @(posedge clk);
    // release first
    if (lv) begin
      if (lc <= mPg[lpg] && lc <= mIn[lip] && lc <= mOut[lop] && lc <= mQ[lq] && lc <= mUsed) begin
        mPg[lpg] -= lc; mIn[lip] -= lc; mOut[lop] -= lc; mQ[lq] -= lc; mUsed -= lc;
      end else mErr = 1;
    end
    eValid = rv;
    if (rv) begin
      c = cellsOf(len);
      fr = POOL - mUsed;
      ok = (mPg[pg] + c <= lim(24, 1, fr)) && (mIn[ip] + c <= lim(40, 1, fr)) &&
           (mQ[q] + c <= lim(28, -1, fr)) && (mOut[op] + c <= lim(40, 1, fr)) &&
           (mUsed + c <= ING_LIM) && (mUsed + c <= EGR_LIM) && (mUsed + c <= POOL);
      eCells = c; eAdmit = ok;
      if (ok) begin
        mPg[pg] += c; mIn[ip] += c; mOut[op] += c; mQ[q] += c; mUsed += c;
      end
    end
    #1;
    chk(respValid === 1'(eValid), "R2 respValid", int'(respValid), eValid);
    if (eValid) begin
      chk(respCells == 7'(eCells), "R1 respCells", int'(respCells), eCells);
      chk(respAdmit == 1'(eAdmit), "R3 R4 R5 R6 decision", int'(respAdmit), eAdmit);
    end else
      chk(respAdmit == 1'b0, "R2 admit without valid", int'(respAdmit), 0);
    chk(relError == 1'(mErr), "R10 relError", int'(relError), mErr);
    chk(poolUsed == 7'(mUsed), "R7 R8 poolUsed", int'(poolUsed), mUsed);
  endtask

  task automatic send(input int len, input int pg, input int ip, input int op, input int q);
    cyc(1, len, pg, ip, op, q, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; reqValid = 0; relValid = 0;
    repeat (2) @(negedge clk);
    modelReset();
    rstN = 1;
    #1;
    // R11
    chk(poolUsed == 0, "R11 poolUsed after reset", int'(poolUsed), 0);
    chk(respValid == 0, "R11 respValid after reset", int'(respValid), 0);
    chk(relError == 0, "R11 relError after reset", int'(relError), 0);
  endtask

  initial begin
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    modelReset();
    doReset();

    // R1 cell counts, R7 pool growth, R8 oversize drop
    send(100, 0, 0, 0, 0);
    chk(respCells == 7'd1, "R1 len 100", int'(respCells), 1);
    chk(poolUsed == 7'd1, "R7 pool after one cell", int'(poolUsed), 1);
    send(144, 0, 0, 0, 0);
    chk(respCells == 7'd1, "R1 len 144", int'(respCells), 1);
    send(145, 0, 0, 0, 0);
    chk(respCells == 7'd2, "R1 len 145", int'(respCells), 2);
    send(352, 0, 0, 0, 0);
    chk(respCells == 7'd2, "R1 len 352", int'(respCells), 2);
    send(353, 0, 0, 0, 0);
    chk(respCells == 7'd3, "R1 len 353", int'(respCells), 3);
    chk(poolUsed == 7'd9, "R7 pool after five packets", int'(poolUsed), 9);
    send(16383, 1, 1, 1, 1);
    chk(respCells == 7'd80, "R1 len 16383", int'(respCells), 80);
    chk(respAdmit == 1'b0, "R6 oversize dropped", int'(respAdmit), 0);
    chk(poolUsed == 7'd9, "R8 drop leaves pool", int'(poolUsed), 9);
    cyc(0, 0, 0, 0, 0, 0, 1, 3, 0, 0, 0, 0);
    chk(poolUsed == 7'd6, "R7 release lowers pool", int'(poolUsed), 6);
    idle();

    // R3 priority-group limit
    doReset();
    send(2432, 1, 1, 1, 1);
    chk(respAdmit == 1'b1, "R3 first 12-cell admitted", int'(respAdmit), 1);
    send(2432, 1, 2, 2, 2);
    chk(respAdmit == 1'b1, "R3 group reaches 24", int'(respAdmit), 1);
    send(2432, 1, 3, 3, 3);
    chk(respAdmit == 1'b0, "R3 group over limit", int'(respAdmit), 0);
    chk(poolUsed == 7'd24, "R8 pool after group drop", int'(poolUsed), 24);

    // R4 R5 queue limit from halved free count, R9 same-cycle release
    doReset();
    for (int k = 0; k < 21; k++) send(64, k % 4, k % 4, 0, 0);
    chk(respAdmit == 1'b1, "R5 21st cell in queue", int'(respAdmit), 1);
    send(64, 1, 1, 0, 0);
    chk(respAdmit == 1'b0, "R4 queue over limit", int'(respAdmit), 0);
    chk(respAdmit == 1'b0, "R5 dynamic limit below static", int'(respAdmit), 0);
    cyc(1, 64, 2, 2, 0, 0, 1, 1, 0, 0, 0, 0);
    chk(respAdmit == 1'b1, "R9 release applied before admit", int'(respAdmit), 1);
    chk(poolUsed == 7'd21, "R9 pool after swap", int'(poolUsed), 21);

    // R6 egress pool ceiling
    doReset();
    for (int i = 0; i < 7; i++) send(1600, i % 4, i % 4, i % 4, i);
    chk(poolUsed == 7'd56, "R6 pool filled to 56", int'(poolUsed), 56);
    send(64, 3, 3, 3, 7);
    chk(respAdmit == 1'b0, "R6 egress pool ceiling", int'(respAdmit), 0);

    // R10 underflow
    doReset();
    cyc(0, 0, 0, 0, 0, 0, 1, 5, 3, 3, 2, 5);
    chk(relError == 1'b1, "R10 underflow flagged", int'(relError), 1);
    chk(poolUsed == 7'd0, "R10 underflow ignored", int'(poolUsed), 0);
    send(64, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0);
    chk(poolUsed == 7'd1, "R10 partial underflow ignored", int'(poolUsed), 1);
    idle();
    chk(relError == 1'b1, "R10 flag sticky", int'(relError), 1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule